// File: doc/BRIEF.md
# Receive Frame Staging Buffer with Dropped-Frame Counter

This block is a small byte-wide staging buffer placed between a receive MAC and a larger downstream receive data FIFO. Bytes arrive from the MAC with a valid strobe and an end-of-frame flag. The buffer stores each byte together with its end-of-frame flag. It offers only complete frames downstream, and each byte leaves when the downstream side signals room. While the downstream side is stalled, the buffer keeps absorbing incoming bytes until its fixed capacity is used up.

Frames are handled whole. The buffer decides whether to admit a frame when the frame's first byte arrives. If the buffer fills before the frame's last byte, the write pointer rolls back to the start of that frame. The remaining bytes of the frame are then ignored up to its end-of-frame flag. Each lost frame adds exactly one to a saturating dropped-frame counter. A one-cycle clear pulse resets the counter. The fill level stays internal. The depth must be a power of two.

Top module: `rx_stage_buf`

## Requirements
- R1: After reset, out_valid is 0 and drop_count is 0.
- R2: Every admitted frame leaves on out_data in arrival order with its bytes unchanged, and out_last is 1 only on the final byte of each frame.
- R3: No byte of a frame is offered downstream before that frame's final byte has been stored. A frame longer than DEPTH therefore delivers nothing and is counted as lost.
- R4: While out_ready is 0 the buffer absorbs up to DEPTH bytes of complete frames, and out_valid, out_data and out_last hold steady until out_ready rises.
- R5: A frame whose first byte arrives while the buffer already holds DEPTH bytes is discarded. Space is judged before any read in the same cycle. All of that frame's bytes up to and including its end-of-frame byte are ignored.
- R6: A frame that runs out of space partway is rolled back so that none of it is delivered, and the space it used is available to the next frame.
- R7: drop_count increases by exactly one for each lost frame, in the cycle after the loss is detected.
- R8: drop_count saturates at its all-ones value.
- R9: A drop_clr pulse sets drop_count to 0 on the next cycle. If a frame is lost in the same cycle, drop_count becomes 1 instead.
- R10: The number of stored bytes never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A byte from the MAC is present |
| in_data | input | DW | Byte from the MAC |
| in_last | input | 1 | The present byte ends its frame |
| out_ready | input | 1 | The downstream FIFO has room this cycle |
| drop_clr | input | 1 | Host read pulse that clears the counter |
| out_valid | output | 1 | A committed byte is offered downstream |
| out_data | output | DW | Byte offered downstream |
| out_last | output | 1 | The offered byte ends its frame |
| drop_count | output | CNT_W | Number of frames lost, saturating |

## Verification
A rollback pointer left in the wrong place shows up downstream within one frame. The bench would see bytes that are not in their in-frame positions, an out_last on the wrong byte, or a byte total that differs from the number of whole frames admitted. A wrong admission decision changes both the delivered byte count and drop_count. A counter slip is visible on drop_count one cycle after the offending byte. Stalled scenarios with exact-fit frames and one-byte-over frames check the full boundary. A narrow counter instance reaches saturation quickly.

// File: rtl/rx_stage_buf.sv
module rx_stage_buf #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [DW-1:0]    in_data,
  input  logic             in_last,
  input  logic             out_ready,
  input  logic             drop_clr,
  output logic             out_valid,
  output logic [DW-1:0]    out_data,
  output logic             out_last,
  output logic [CNT_W-1:0] drop_count
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] CAP = (AW+1)'(DEPTH);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [DW:0] mem [DEPTH];
  logic [AW:0] wr_ptr, cm_ptr, rd_ptr;
  logic        dropping;

  wire [AW:0] fill  = wr_ptr - rd_ptr;
  wire        full  = (fill == CAP);
  wire        take  = in_valid && !dropping;
  wire        wr_go = take && !full;
  wire        lose  = take && full;
  wire        rd_go = out_valid && out_ready;

  assign out_valid = (rd_ptr != cm_ptr);
  assign {out_last, out_data} = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk)
    if (wr_go) mem[wr_ptr[AW-1:0]] <= {in_last, in_data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      cm_ptr   <= '0;
      rd_ptr   <= '0;
      dropping <= 1'b0;
    end else begin
      if (rd_go) rd_ptr <= rd_ptr + 1'b1;
      if (lose) begin
        wr_ptr   <= cm_ptr;
        dropping <= !in_last;
      end else if (wr_go) begin
        wr_ptr <= wr_ptr + 1'b1;
        if (in_last) cm_ptr <= wr_ptr + 1'b1;
      end else if (in_valid && dropping && in_last) begin
        dropping <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      drop_count <= '0;
    else if (drop_clr)
      drop_count <= {{(CNT_W-1){1'b0}}, lose};
    else if (lose && drop_count != CMAX)
      drop_count <= drop_count + 1'b1;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) fill <= CAP); // R10
  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)); // R4
  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    drop_count == CMAX && !drop_clr |=> drop_count == CMAX); // R8
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !drop_clr |=> drop_count == $past(drop_count) || drop_count == $past(drop_count) + 1'b1); // R7
  AST_CNT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    drop_clr |=> drop_count <= CNT_W'(1)); // R9
endmodule

// File: tb/rx_stage_buf_test.sv
module rx_stage_buf_test;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_last = 0, out_ready = 0, drop_clr = 0;
  logic [7:0] in_data = 0;
  logic out_valid, out_last;
  logic [7:0] out_data;
  logic [31:0] drop_count;
  logic s_ready = 1, s_clr = 0, s_valid, s_last;
  logic [7:0] s_data;
  logic [1:0] s_count;

  always #2 clk = ~clk;

  rx_stage_buf uut (.clk, .rst_n, .in_valid, .in_data, .in_last, .out_ready, .drop_clr,
                    .out_valid, .out_data, .out_last, .drop_count);
  rx_stage_buf #(.DEPTH(4), .CNT_W(2)) uut_sat (.clk, .rst_n, .in_valid, .in_data, .in_last,
    .out_ready(s_ready), .drop_clr(s_clr), .out_valid(s_valid), .out_data(s_data),
    .out_last(s_last), .drop_count(s_count));

  // columns: stall, frames, length, expected drops, expected delivered bytes
  localparam int VEC [7][5] = '{
    '{0, 4,  20, 0,  80},
    '{1, 5,  40, 2, 120},
    '{1, 4,  32, 0, 128},
    '{1, 5,  32, 1, 128},
    '{0, 1, 200, 1,   0},
    '{1, 3,   1, 0,   3},
    '{1, 2, 128, 1, 128}};

  int n_chk = 0, n_err = 0;
  int rx_bytes = 0, rx_frames = 0, bad = 0, pos = 0, cur_len = 1;

  always @(negedge clk)
    if (rst_n && out_valid && out_ready) begin
      if (out_data != pos[7:0]) bad++;
      if (out_last != (pos == cur_len - 1)) bad++;
      rx_bytes++;
      if (out_last) begin rx_frames++; pos = 0; end else pos++;
    end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send(input int len);
    for (int i = 0; i < len; i++) begin
      in_valid = 1; in_data = i[7:0]; in_last = (i == len - 1);
      @(posedge clk); #1;
    end
    in_valid = 0; in_last = 0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic string vtag(input int v);
    case (v)
      1: return "R6";
      2: return "R4";
      3: return "R5";
      4: return "R3";
      6: return "R5";
      default: return "R2";
    endcase
  endfunction

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
  end

  initial begin
    wait_cyc(3);
    rst_n = 1;
    wait_cyc(1);
    check("R1", "out_valid after reset", out_valid, 0);
    check("R1", "drop_count after reset", drop_count, 0);

    for (int v = 0; v < 7; v++) begin
      int base;
      base = drop_count;
      cur_len = VEC[v][2]; rx_bytes = 0; rx_frames = 0; bad = 0; pos = 0;
      out_ready = (VEC[v][0] == 0);
      for (int f = 0; f < VEC[v][1]; f++) send(cur_len);
      out_ready = 1;
      wait_cyc(300);
      check("R7", $sformatf("vector %0d drops", v), drop_count - base, VEC[v][3]);
      check(vtag(v), $sformatf("vector %0d bytes", v), rx_bytes, VEC[v][4]);
      check(vtag(v), $sformatf("vector %0d frames", v), rx_frames, VEC[v][4] / cur_len);
      check("R2", $sformatf("vector %0d content errors", v), bad, 0);
    end

    // R4: output holds while stalled
    cur_len = 3; pos = 0; rx_bytes = 0; out_ready = 0;
    send(3);
    wait_cyc(2);
    check("R4", "valid under stall", out_valid, 1);
    check("R4", "first byte under stall", out_data, 0);
    wait_cyc(5);
    check("R4", "byte still held", out_data, 0);
    check("R4", "last flag held", out_last, 0);
    out_ready = 1;
    wait_cyc(20);
    check("R4", "bytes after release", rx_bytes, 3);

    // R9: clear
    check("R7", "total drops", drop_count, 5);
    drop_clr = 1; wait_cyc(1); drop_clr = 0;
    check("R9", "count after clear", drop_count, 0);

    // R9: clear coinciding with a lost frame
    cur_len = 128; pos = 0; rx_bytes = 0; out_ready = 0;
    send(128);
    in_valid = 1; in_data = 0; in_last = 1; drop_clr = 1;
    wait_cyc(1);
    in_valid = 0; in_last = 0; drop_clr = 0;
    check("R9", "clear with drop", drop_count, 1);
    out_ready = 1;
    wait_cyc(200);
    check("R5", "full frame kept, single dropped", rx_bytes, 128);

    // R8: saturation on the narrow instance
    wait_cyc(20);
    s_clr = 1; wait_cyc(1); s_clr = 0;
    check("R9", "narrow counter cleared", s_count, 0);
    s_ready = 0;
    send(4);
    send(1);
    check("R7", "narrow counter one drop", s_count, 1);
    send(1); send(1);
    check("R8", "narrow counter at max", s_count, 3);
    send(1); send(1);
    check("R8", "narrow counter saturated", s_count, 3);
    check("R10", "narrow buffer still offers data", s_valid, 1);
    summary();
  end
endmodule